// File: doc/BRIEF.md
# Programmable 24-bit Reload Timer

This block is a down-counting interval timer with a 24-bit count. A host programs it through a byte-wide write port. Three addresses hold the bytes of a reload value and a fourth holds a mode byte. The counter advances on an internal tick that the block derives from its own clock, one tick every six clock cycles.

A timer cycle begins with a start command written into the mode byte. In single-shot mode the output goes active for the length of one count and then the timer stops. In auto-reload mode the timer runs forever. Each time the count expires it emits an active pulse eight ticks wide and reloads. The output level for the active state can be inverted. The reload value can be locked against writes. A running timer can be halted, and a start issued mid-cycle restarts the count.

The running flag and the live count are brought out so that the state of the timer can be observed.

Top module: `reload_timer24`

## Requirements
- R1: After reset the count, reload value, byte buffers and mode byte are zero, `running` is 0 and `timerOut` is 1.
- R2: While running, the count drops by exactly one per tick, and ticks are spaced exactly six clock cycles apart.
- R3: Address 1 (middle byte) and address 2 (top byte) write only into holding buffers. A write to address 0 (low byte) commits {top buffer, middle buffer, written byte} to the reload value in that same cycle. Address 3 is the mode byte.
- R4: While mode bit 0 is set, writes to addresses 0, 1 and 2 change neither the reload value nor the buffers.
- R5: Mode bit 4 selects polarity. When it is 0 the output idles at 1 and is active at 0. When it is 1 the output idles at 0 and is active at 1.
- R6: With mode bit 5 at 0, a start loads the reload value and drives the output active. The output returns to idle and `running` falls on the tick that takes the count to zero.
- R7: With mode bit 5 at 1, a start loads the reload value with the output idle. Each time the count expires the output goes active for exactly 8 ticks and the count reloads, so a reload of N gives a period of N ticks.
- R8: In auto-reload mode a reload value below 9 loads as 9.
- R9: A start written while a cycle is running reloads the count at once and emits no pulse for the interrupted cycle.
- R10: A mode write with bit 6 set and bits 5 and 7 clear stops the timer and leaves the output idle. The reload value is unaffected, so the next start loads it again.
- R11: Writing mode bit 7 as 1 is a one-cycle start event that sets `running` on the next edge. It is not retained, so a finished single-shot stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 2 | Register address: 0 low, 1 middle, 2 top, 3 mode |
| wrData | input | 8 | Write data byte |
| timerOut | output | 1 | Timer output, level set by mode bit 4 |
| running | output | 1 | Timer is counting |
| count | output | 24 | Current counter value |

## Verification
The assertions assume that mode bit 5 changes only in a write that also starts the timer or in a halt write. They also assume that a single-shot cycle is never switched to auto-reload while its count sits at zero. Under either of those conditions the auto-reload floor and the step-by-one rule on the count would not hold. The stimulus respects this: every mode write is a plain start, a halt, a polarity or protection setting, or a clear to zero, and each write goes through one task that holds the strobe for exactly one cycle.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int RTM_ADDR_W   = 2;
  localparam int RTM_MODE_ADR = 3;

  typedef struct packed {
    logic loadCnt;   // copy (possibly floored) reload value into counter
    logic decCnt;    // step counter down by one, saturating at zero
    logic clampMin;  // apply the auto-reload floor on this load
    logic wrBlock;   // protection active: ignore byte writes
  } rtm_strobe_t;
endpackage

// File: rtl/rtm_datapath.sv
module rtm_datapath
  import rtm_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int MIN_LOAD = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [RTM_ADDR_W-1:0] wrAddr,
  input  logic [7:0]            wrData,
  input  rtm_strobe_t           strobe,
  output logic [CNT_W-1:0]      count,
  output logic                  cntLeOne,
  output logic [CNT_W-1:0]      reloadVal
);
  localparam int NBYTES = CNT_W / 8;

  logic [7:0]       bufByte [NBYTES];
  logic [CNT_W-1:0] staged;
  logic [CNT_W-1:0] loadVal;
  logic             byteWr;

  assign byteWr = wrEn && !strobe.wrBlock;

  // byte 0 has no buffer; upper lanes are held until the low byte commits
  assign bufByte[0] = wrData;
  for (genvar i = 1; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufByte[i] <= '0;
      end else if (byteWr && wrAddr == RTM_ADDR_W'(i)) begin
        bufByte[i] <= wrData;
      end
    end
    assign staged[8*i +: 8] = bufByte[i];
  end
  assign staged[7:0] = bufByte[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (byteWr && wrAddr == '0) begin
      reloadVal <= staged;
    end
  end

  always_comb begin
    loadVal = reloadVal;
    if (strobe.clampMin && reloadVal < CNT_W'(MIN_LOAD)) begin
      loadVal = CNT_W'(MIN_LOAD);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadCnt) begin
      count <= loadVal;
    end else if (strobe.decCnt && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign cntLeOne = (count <= CNT_W'(1));
endmodule

// File: rtl/rtm_ctrl.sv
module rtm_ctrl
  import rtm_pkg::*;
#(
  parameter int PRESCALE    = 6,
  parameter int PULSE_TICKS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [RTM_ADDR_W-1:0] wrAddr,
  input  logic [7:0]            wrData,
  input  logic                  cntLeOne,
  output rtm_strobe_t           strobe,
  output logic                  timerOut,
  output logic                  running,
  output logic [7:0]            modeBits
);
  localparam int PW  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int PCW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0]  presc;
  logic           tick;
  logic           modeWr, startEv, haltEv;
  logic           autoMode, polHigh;
  logic           ssActive;
  logic [PCW-1:0] pulseCnt;
  logic           expire;
  logic           outActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
    end else if (presc == PW'(PRESCALE - 1)) begin
      presc <= '0;
    end else begin
      presc <= presc + 1'b1;
    end
  end
  assign tick = (presc == PW'(PRESCALE - 1));

  assign modeWr   = wrEn && wrAddr == RTM_ADDR_W'(RTM_MODE_ADR);
  assign startEv  = modeWr && wrData[7];
  assign haltEv   = modeWr && wrData[6] && !wrData[5] && !wrData[7];
  assign autoMode = modeBits[5];
  assign polHigh  = modeBits[4];
  assign expire   = tick && running && cntLeOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits <= '0;
    end else if (modeWr) begin
      modeBits <= wrData & 8'h71;  // start bit is an event, never stored
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      ssActive <= 1'b0;
      pulseCnt <= '0;
    end else if (startEv) begin
      running  <= 1'b1;
      ssActive <= !wrData[5];
      pulseCnt <= '0;
    end else if (haltEv) begin
      running  <= 1'b0;
      ssActive <= 1'b0;
      pulseCnt <= '0;
    end else if (tick && running) begin
      if (autoMode) begin
        if (cntLeOne) begin
          pulseCnt <= PCW'(PULSE_TICKS);
        end else if (pulseCnt != '0) begin
          pulseCnt <= pulseCnt - 1'b1;
        end
      end else if (cntLeOne) begin
        running  <= 1'b0;
        ssActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadCnt  = startEv || (expire && autoMode);
    strobe.decCnt   = tick && running && !(autoMode && cntLeOne);
    strobe.clampMin = startEv ? wrData[5] : autoMode;
    strobe.wrBlock  = modeBits[0];
  end

  assign outActive = autoMode ? (pulseCnt != '0) : ssActive;
  assign timerOut  = polHigh ? outActive : !outActive;
endmodule

// File: rtl/reload_timer24.sv
module reload_timer24
  import rtm_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PRESCALE    = 6,
  parameter int PULSE_TICKS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  output logic             timerOut,
  output logic             running,
  output logic [CNT_W-1:0] count
);
  localparam int MIN_PERIOD = PULSE_TICKS + 1;

  rtm_strobe_t      strobe;
  logic             cntLeOne;
  logic [7:0]       modeBits;
  logic [CNT_W-1:0] reloadVal;

  rtm_ctrl #(.PRESCALE(PRESCALE), .PULSE_TICKS(PULSE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntLeOne(cntLeOne), .strobe(strobe), .timerOut(timerOut),
    .running(running), .modeBits(modeBits)
  );

  rtm_datapath #(.CNT_W(CNT_W), .MIN_LOAD(MIN_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .count(count), .cntLeOne(cntLeOne), .reloadVal(reloadVal)
  );
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [7:0]       wrData,
  input logic             running,
  input logic             timerOut,
  input logic [CNT_W-1:0] count,
  input logic [7:0]       modeBits,
  input logic [CNT_W-1:0] reloadVal
);
  logic startWr, haltWr;
  assign startWr = wrEn && wrAddr == 2'd3 && wrData[7];
  assign haltWr  = wrEn && wrAddr == 2'd3 && wrData[6] && !wrData[5] && !wrData[7];

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> running);  // R11

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    haltWr |=> (!running && $stable(reloadVal)));  // R10

  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    modeBits[0] |=> $stable(reloadVal));  // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (running && !modeBits[5] && !startWr) |=>
      (count == $past(count) || count == $past(count) - 1'b1));  // R2

  AST_AUTO_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (running && modeBits[5]) |-> (count != '0));  // R8

  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrEn) |=> (timerOut == !modeBits[4]));  // R6
endmodule

bind reload_timer24 rtm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .running(running), .timerOut(timerOut), .count(count),
  .modeBits(modeBits), .reloadVal(reloadVal)
);

// File: tb/reload_timer24_bench.sv
`timescale 1ns/1ps
module reload_timer24_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        timerOut;
  logic        running;
  logic [23:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_timer24 u_reload_timer24 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerOut(timerOut), .running(running), .count(count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setReload(input logic [23:0] v);
    wr(2'd1, v[15:8]);
    wr(2'd2, v[23:16]);
    wr(2'd0, v[7:0]);
  endtask

  task automatic waitOut(input logic lvl, input int maxCyc, output int n);
    n = 0;
    while (timerOut !== lvl && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check(timerOut === 1'b1, "R1 out", timerOut, 1);
    check(running === 1'b0, "R1 running", running, 0);
    check(count === 24'd0, "R1 count", count, 0);
  endtask

  task automatic t_atomic();
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h34);
    wr(2'd3, 8'h80);
    check(count === 24'd0, "R3 buffers not committed", count, 0);
    wr(2'd3, 8'h40);
    check(running === 1'b0, "R10 halt single", running, 0);
    wr(2'd0, 8'h56);
    wr(2'd3, 8'h80);
    check(count === 24'h341256, "R3 commit on low byte", count, 24'h341256);
    wr(2'd3, 8'h40);
  endtask

  task automatic t_single();
    int act = 0;
    int lastChg = -1;
    int n = 0;
    bit spaceOk = 1'b1;
    logic [23:0] prev;
    setReload(24'd5);
    wr(2'd3, 8'h80);
    check(running === 1'b1, "R11 running after start", running, 1);
    check(timerOut === 1'b0, "R6 active low on start", timerOut, 0);
    check(count === 24'd5, "R6 load", count, 5);
    prev = count;
    while (running === 1'b1 && n < 100) begin
      if (timerOut === 1'b0) act++;
      @(negedge clk);
      n++;
      if (count !== prev) begin
        if (count !== prev - 1) spaceOk = 1'b0;
        if (lastChg >= 0 && n - lastChg != 6) spaceOk = 1'b0;
        lastChg = n;
        prev = count;
      end
    end
    check(spaceOk, "R2 step and spacing", spaceOk, 1);
    check(act >= 25 && act <= 30, "R6 active length", act, 30);
    check(timerOut === 1'b1, "R6 idle after zero", timerOut, 1);
    check(count === 24'd0, "R6 count at zero", count, 0);
    repeat (40) @(negedge clk);
    check(running === 1'b0, "R11 start not retained", running, 0);
  endtask

  task automatic t_polarity();
    wr(2'd3, 8'h10);
    check(timerOut === 1'b0, "R5 idle low", timerOut, 0);
    wr(2'd3, 8'h90);
    check(timerOut === 1'b1, "R5 active high", timerOut, 1);
    wr(2'd3, 8'h50);
    check(timerOut === 1'b0, "R5 idle low after halt", timerOut, 0);
    wr(2'd3, 8'h00);
    check(timerOut === 1'b1, "R5 idle high", timerOut, 1);
  endtask

  task automatic measureAuto(input string req, input int expPeriod);
    int n;
    int hi;
    int lo;
    waitOut(1'b1, 400, n);
    waitOut(1'b0, 400, hi);
    waitOut(1'b1, 400, lo);
    check(hi == 48, {req, " pulse width"}, hi, 48);
    check(hi + lo == expPeriod, {req, " period"}, hi + lo, expPeriod);
  endtask

  task automatic t_auto();
    setReload(24'd10);
    wr(2'd3, 8'hB0);
    check(timerOut === 1'b0 && count === 24'd10, "R7 idle on start", count, 10);
    measureAuto("R7", 60);
    wr(2'd3, 8'h40);
    check(running === 1'b0 && timerOut === 1'b1, "R10 halt auto", {running, timerOut}, 1);
    repeat (20) @(negedge clk);
    wr(2'd3, 8'h80);
    check(count === 24'd10, "R10 reload kept after halt", count, 10);
    wr(2'd3, 8'h40);
  endtask

  task automatic t_clamp();
    setReload(24'd3);
    wr(2'd3, 8'hB0);
    check(count === 24'd9, "R8 floor on load", count, 9);
    measureAuto("R8", 54);
    wr(2'd3, 8'h40);
  endtask

  task automatic t_restart();
    bit saw = 1'b0;
    setReload(24'd20);
    wr(2'd3, 8'hB0);
    repeat (90) begin
      @(negedge clk);
      if (timerOut === 1'b1) saw = 1'b1;
    end
    wr(2'd3, 8'hB0);
    check(count === 24'd20, "R9 reload on restart", count, 20);
    repeat (60) begin
      @(negedge clk);
      if (timerOut === 1'b1) saw = 1'b1;
    end
    check(saw == 1'b0, "R9 no pulse", saw, 0);
    wr(2'd3, 8'h40);
  endtask

  task automatic t_protect();
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h55);
    wr(2'd1, 8'h77);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h80);
    check(count === 24'd20, "R4 reload locked", count, 20);
    wr(2'd3, 8'h40);
    wr(2'd0, 8'h02);
    wr(2'd3, 8'h80);
    check(count === 24'h000002, "R4 buffer locked", count, 2);
    wr(2'd3, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_atomic();
    t_single();
    t_polarity();
    t_auto();
    t_clamp();
    t_restart();
    t_protect();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule